// File: doc/BRIEF.md
# LFSR Window Match Checker

This block confirms that a pseudo-random generator produces its deterministic sequence correctly when every noise source is switched off. With no entropy, the generator's output is simply a 64-bit Galois LFSR stepped a known number of times. The block takes in a burst of sampled words and throws away the first of them, because nothing is known about how long it waited before that word was read. It keeps the other words in registers. From a fixed starting state it then advances its own copy of the LFSR by one step per clock. At every step it compares that state against all the stored words at once and adds the number of equal words to a running count.

Samples may be read late, so the search covers a window of step offsets and does not expect one exact point. A quorum of matches is enough to pass, so one bad sample is allowed. The search ends on the first step where the quorum is reached. If the window runs out first, the block reports failure. The verdict, the match count and the offset at which each word matched stay on the outputs until the next start pulse.

Top module: `lfsr_window_checker`

## Requirements
- R1: While `rst` is high, and on the edge after it, `done`, `pass`, `match_count` and every `hit_offsets` field are zero.
- R2: After a `start` pulse, the block counts the first 8 cycles with `in_valid` high, and cycles with `in_valid` low are skipped. The first of these words is discarded. The next 7 are kept as checked words 0 to 6, in arrival order.
- R3: The reference state at offset 0 is 0xb8820c7bd387e32c. Each step moves the state left by one bit. When the bit shifted out (old bit 63) is 1, the result is then XORed with 0x231dcee91262b8a3.
- R4: At each offset, every checked word equal to the reference state adds one to `match_count`. All 7 comparisons are made in the same clock, and duplicate words each count.
- R5: If the count reaches 6 at offset k, the search stops there. `done` and `pass` rise at the (k+1)th rising edge after the edge that captured the last word.
- R6: Offsets 0 through 40000 inclusive are searched. If the count is still below 6 after offset 40000, `done` rises with `pass` low at edge 40001, and `match_count` holds the number of matches found.
- R7: `hit_offsets[16j+15:16j]` holds the offset at which checked word j matched. A word that did not match before the search stopped reads 0.
- R8: Once `done` is high, the outputs hold until the next `start`, and `in_valid` words have no effect.
- R9: On the edge that samples `start`, `done`, `pass`, `match_count` and `hit_offsets` are cleared and capture begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a capture-and-search run |
| in_valid | input | 1 | Marks `in_data` as a sampled word |
| in_data | input | 64 | Sampled generator word |
| done | output | 1 | Verdict available |
| pass | output | 1 | Quorum reached inside the window |
| match_count | output | 3 | Matches accumulated by the end of the search |
| hit_offsets | output | 112 | Seven 16-bit match offsets, word j at bits 16j+15:16j |

## Verification
Capture takes one register stage: the word presented before an edge is stored at that edge. The verdict comes from a state that was loaded on the capture edge of the last word, so a run that stops at offset k raises `done` exactly k+1 edges after that capture. The bench counts edges from the final capture and compares the count with the stop offset it works out from its own model of the sequence. It samples every output on falling edges. Clear-on-start and the holding of results are checked on the falling edge after the stimulus edge.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    localparam int SEQ_W = 64;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_SEARCH,
        PH_DONE
    } phase_e;

    function automatic logic [SEQ_W-1:0] lfsr_next(input logic [SEQ_W-1:0] cur,
                                                   input logic [SEQ_W-1:0] poly);
        logic [SEQ_W-1:0] shifted;
        shifted = {cur[SEQ_W-2:0], 1'b0};
        return cur[SEQ_W-1] ? (shifted ^ poly) : shifted;
    endfunction

endpackage

// File: rtl/lwc_capture.sv
module lwc_capture #(
    parameter int BURST_WORDS = 8,
    parameter int KEEP_WORDS  = BURST_WORDS - 1,
    parameter int W           = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear,
    input  logic                           enable,
    input  logic                           in_valid,
    input  logic [W-1:0]                   in_data,
    output logic [KEEP_WORDS-1:0][W-1:0]   words,
    output logic                           last_word
);
    localparam int IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    logic [IDX_W-1:0] idx;
    logic             take;

    assign take      = enable && in_valid;
    assign last_word = take && (idx == IDX_W'(BURST_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (take) begin
            idx <= last_word ? '0 : idx + 1'b1;
        end
    end

    for (genvar i = 0; i < KEEP_WORDS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (take && idx == IDX_W'(i + 1)) begin
                words[i] <= in_data;
            end
        end
    end

endmodule

// File: rtl/lwc_stepper.sv
module lwc_stepper #(
    parameter int                        OFF_W = 16,
    parameter int                        LAST  = 40000,
    parameter logic [lwc_pkg::SEQ_W-1:0] POLY  = 64'h231dcee91262b8a3,
    parameter logic [lwc_pkg::SEQ_W-1:0] SEED  = 64'hb8820c7bd387e32c
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      advance,
    output logic [lwc_pkg::SEQ_W-1:0] state,
    output logic [OFF_W-1:0]          offset,
    output logic                      at_last
);
    assign at_last = (offset == OFF_W'(LAST));

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state  <= SEED;
            offset <= '0;
        end else if (advance) begin
            state  <= lwc_pkg::lfsr_next(state, POLY);
            offset <= offset + 1'b1;
        end
    end

endmodule

// File: rtl/lwc_compare.sv
module lwc_compare #(
    parameter int N     = 7,
    parameter int W     = 64,
    parameter int CNT_W = 3
) (
    input  logic [W-1:0]          ref_state,
    input  logic [N-1:0][W-1:0]   words,
    output logic [N-1:0]          equal,
    output logic [CNT_W-1:0]      hits
);
    for (genvar j = 0; j < N; j++) begin : g_cmp
        assign equal[j] = (words[j] == ref_state);
    end

    always_comb begin
        hits = '0;
        for (int j = 0; j < N; j++) begin
            hits = hits + CNT_W'(equal[j]);
        end
    end

endmodule

// File: rtl/lfsr_window_checker.sv
module lfsr_window_checker #(
    parameter int                        BURST_WORDS    = 8,
    parameter int                        ALLOWED_MISSES = 1,
    parameter int                        WINDOW_LAST    = 40000,
    parameter logic [lwc_pkg::SEQ_W-1:0] POLY           = 64'h231dcee91262b8a3,
    parameter logic [lwc_pkg::SEQ_W-1:0] SEED           = 64'hb8820c7bd387e32c,
    localparam int CHECK_WORDS = BURST_WORDS - 1,
    localparam int QUORUM      = CHECK_WORDS - ALLOWED_MISSES,
    localparam int OFF_W       = $clog2(WINDOW_LAST + 1),
    localparam int CNT_W       = $clog2(CHECK_WORDS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         in_valid,
    input  logic [lwc_pkg::SEQ_W-1:0]    in_data,
    output logic                         done,
    output logic                         pass,
    output logic [CNT_W-1:0]             match_count,
    output logic [CHECK_WORDS*OFF_W-1:0] hit_offsets
);
    import lwc_pkg::*;

    phase_e                               phase;
    logic [CHECK_WORDS-1:0][SEQ_W-1:0]    words;
    logic                                 last_word;
    logic [SEQ_W-1:0]                     lfsr_state;
    logic [OFF_W-1:0]                     offset;
    logic                                 at_last;
    logic [CHECK_WORDS-1:0]               equal;
    logic [CNT_W-1:0]                     step_hits;
    logic [CNT_W:0]                       sum;
    logic [CNT_W-1:0]                     next_count;
    logic                                 quorum_met;
    logic                                 searching;
    logic [CHECK_WORDS-1:0][OFF_W-1:0]    hits_q;

    assign searching = (phase == PH_SEARCH);

    lwc_capture #(
        .BURST_WORDS(BURST_WORDS),
        .KEEP_WORDS (CHECK_WORDS),
        .W          (SEQ_W)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .enable   (phase == PH_LOAD && !start),
        .in_valid (in_valid),
        .in_data  (in_data),
        .words    (words),
        .last_word(last_word)
    );

    lwc_stepper #(
        .OFF_W(OFF_W),
        .LAST (WINDOW_LAST),
        .POLY (POLY),
        .SEED (SEED)
    ) u_stepper (
        .clk    (clk),
        .rst    (rst),
        .load   (last_word),
        .advance(searching && !start),
        .state  (lfsr_state),
        .offset (offset),
        .at_last(at_last)
    );

    lwc_compare #(
        .N    (CHECK_WORDS),
        .W    (SEQ_W),
        .CNT_W(CNT_W)
    ) u_compare (
        .ref_state(lfsr_state),
        .words    (words),
        .equal    (equal),
        .hits     (step_hits)
    );

    assign sum        = {1'b0, match_count} + {1'b0, step_hits};
    assign next_count = (sum > (CNT_W+1)'(CHECK_WORDS)) ? CNT_W'(CHECK_WORDS) : sum[CNT_W-1:0];
    assign quorum_met = (sum >= (CNT_W+1)'(QUORUM));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            done        <= 1'b0;
            pass        <= 1'b0;
            match_count <= '0;
            hits_q      <= '0;
        end else if (start) begin
            phase       <= PH_LOAD;
            done        <= 1'b0;
            pass        <= 1'b0;
            match_count <= '0;
            hits_q      <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: begin
                    if (last_word) phase <= PH_SEARCH;
                end
                PH_SEARCH: begin
                    match_count <= next_count;
                    for (int j = 0; j < CHECK_WORDS; j++) begin
                        if (equal[j]) hits_q[j] <= offset;
                    end
                    if (quorum_met) begin
                        phase <= PH_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end else if (at_last) begin
                        phase <= PH_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign hit_offsets = hits_q;

endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
    parameter int                        CNT_W  = 3,
    parameter int                        QUORUM = 6,
    parameter int                        HIT_W  = 112,
    parameter logic [lwc_pkg::SEQ_W-1:0] POLY   = 64'h231dcee91262b8a3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic                      done,
    input logic                      pass,
    input logic [CNT_W-1:0]          match_count,
    input logic [HIT_W-1:0]          hit_offsets,
    input logic                      searching,
    input logic [lwc_pkg::SEQ_W-1:0] lfsr_state
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done && !pass && match_count == '0 && hit_offsets == '0)); // R1

    AST_LFSR_STEP: assert property (@(posedge clk) disable iff (rst)
        (searching && !start) |=> lfsr_state == lwc_pkg::lfsr_next($past(lfsr_state), POLY)); // R3

    AST_COUNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!start && !done) |=> match_count >= $past(match_count)); // R4

    AST_PASS_HAS_QUORUM: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && match_count >= CNT_W'(QUORUM))); // R5

    AST_FAIL_BELOW_QUORUM: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> match_count < CNT_W'(QUORUM)); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass) && $stable(match_count) && $stable(hit_offsets))); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !pass && match_count == '0 && hit_offsets == '0)); // R9

endmodule

bind lfsr_window_checker lwc_checker #(
    .CNT_W (CNT_W),
    .QUORUM(QUORUM),
    .HIT_W (CHECK_WORDS*OFF_W),
    .POLY  (POLY)
) u_lwc_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .pass       (pass),
    .match_count(match_count),
    .hit_offsets(hit_offsets),
    .searching  (searching),
    .lfsr_state (lfsr_state)
);

// File: tb/test_lfsr_window_checker.sv
module test_lfsr_window_checker;
    localparam int  NW     = 7;
    localparam int  OW     = 16;
    localparam int  LAST   = 40000;
    localparam int  NEED   = 6;
    localparam longint unsigned POLYC = 64'h231dcee91262b8a3;
    localparam longint unsigned SEEDC = 64'hb8820c7bd387e32c;
    localparam int  NVEC   = 7;

    // columns: discarded-word offset, checked words 0..6 offsets, gap flag; -1 = word not in sequence
    localparam int VEC [NVEC][9] = '{
        '{-1,     0,     1,     2,     3,     4,     5,     6, 0},
        '{ 0,     1,     2,     3,     4,     5,     6,     7, 1},
        '{-1,   156,   150,   151,   155,   152,    -1,   153, 0},
        '{-1,     0,     2,     2,     2,     2,     2,     2, 1},
        '{-1, 20000, 20001, 20002, 20003,    -1, 20004, 20005, 0},
        '{-1, 39995, 39996, 39997, 39998, 39999, 40000,    -1, 0},
        '{-1, 39996, 39997, 39998, 39999, 40000, 40001,    -1, 0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   in_data = '0;
    logic          done;
    logic          pass;
    logic [2:0]    match_count;
    logic [NW*OW-1:0] hit_offsets;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lfsr_window_checker i_lfsr_window_checker (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
        .done(done), .pass(pass), .match_count(match_count), .hit_offsets(hit_offsets)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] state_at(input int off);
        logic [63:0] s = SEEDC;
        if (off < 0) return 64'h0;
        for (int i = 0; i < off; i++) s = s[63] ? ({s[62:0], 1'b0} ^ POLYC) : {s[62:0], 1'b0};
        return s;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0;
    endtask

    task automatic run_vector(input int v);
        int stop_off, cnt, end_off, n;
        bit exp_pass;
        pulse_start();
        chk(done == 1'b0 && match_count == 3'd0 && hit_offsets == '0, "R9 start clears", done, 0);
        for (int w = 0; w < 8; w++) begin
            if (VEC[v][8] != 0) begin
                in_valid = 1'b0; in_data = 64'hdead; @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = state_at(VEC[v][w]);
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
        end
        // expected outcome from the requirements (R4, R5, R6)
        stop_off = -1; cnt = 0;
        for (int s = 0; s <= LAST; s++) begin
            for (int j = 0; j < NW; j++) if (VEC[v][j+1] == s) cnt++;
            if (cnt >= NEED) begin stop_off = s; break; end
        end
        exp_pass = (stop_off >= 0);
        end_off  = exp_pass ? stop_off : LAST;
        if (cnt > NW) cnt = NW;
        n = 0;
        while (!done && n < LAST + 10) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == end_off + 1, exp_pass ? "R5 done timing" : "R6 window end timing", n, end_off + 1);
        chk(pass == exp_pass, exp_pass ? "R5 pass" : "R6 fail verdict", pass, exp_pass);
        chk(match_count == 3'(cnt), "R4 match count", match_count, cnt);
        for (int j = 0; j < NW; j++) begin
            int e = (VEC[v][j+1] >= 0 && VEC[v][j+1] <= end_off) ? VEC[v][j+1] : 0;
            chk(hit_offsets[j*OW +: OW] == 16'(e), "R7 hit offset", hit_offsets[j*OW +: OW], e);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit held_done, held_pass;
        logic [2:0] held_cnt;
        logic [NW*OW-1:0] held_hits;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 0 && pass == 0 && match_count == 0 && hit_offsets == '0, "R1 reset state", done, 0);
        rst = 1'b0;
        // R2/R8: words without start are ignored
        in_valid = 1'b1; in_data = SEEDC;
        repeat (4) @(posedge clk);
        @(negedge clk); in_valid = 1'b0;
        chk(done == 0 && match_count == 0, "R8 idle words ignored", match_count, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_vector(v);
            if (v == 0) begin
                // R8: results hold and words are ignored after done
                held_done = done; held_pass = pass; held_cnt = match_count; held_hits = hit_offsets;
                for (int k = 0; k < 5; k++) begin
                    in_valid = 1'b1; in_data = state_at(k + 6);
                    @(posedge clk); @(negedge clk);
                end
                in_valid = 1'b0;
                chk(done == held_done && pass == held_pass && match_count == held_cnt
                    && hit_offsets == held_hits, "R8 result held", match_count, held_cnt);
            end
        end

        // R1: reset in the middle of a search
        pulse_start();
        for (int w = 0; w < 8; w++) begin
            in_valid = 1'b1; in_data = state_at(w + 50);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(done == 0 && pass == 0 && match_count == 0 && hit_offsets == '0, "R1 reset mid-search", match_count, 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule